// File: doc/BRIEF.md
# Lookup-Table Significand Rounder

This block rounds a significand to nearest, ties upward, without a carry chain across the full width. Only the low `TBL_L-1` significand bits and the most significant discarded bit are used. Together they address a table of `2^TBL_L` entries, each `TBL_L-1` bits wide. The table output replaces the low field, and every bit above that field passes through untouched.

Because no carry may leave the low field, the address whose low bits are all ones returns all ones. For that address the block truncates where exact rounding would have carried upward. This is the only address that gives a wrong result. At the default `TBL_L = 8`, 255 of the 256 addresses round exactly.

The table contents are computed at elaboration time from the rounding rule. The result is registered once, with a valid qualifier. A flag output marks each result in which the truncation substitute was taken.

Top module: `rom_rounder`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after it rises, `valid_o`, `sat_o` and `sig_o` are all zero.
- R2: `valid_o` equals the `valid_i` of the previous clock cycle. Each result appears exactly one cycle after its input.
- R3: Bits `SIG_W-1` down to `TBL_L-1` of `sig_o` equal the same bits of the accepted `sig_i`.
- R4: When the accepted `ext_i` is 0, the low `TBL_L-1` bits of `sig_o` equal the low bits of `sig_i`.
- R5: When the accepted `ext_i` is 1 and the low `TBL_L-1` bits of `sig_i` are not all ones, the low field of `sig_o` is the input low field plus one.
- R6: When the low `TBL_L-1` bits of `sig_i` are all ones, the low field of `sig_o` is all ones for either value of `ext_i`. `sat_o` is 1 exactly when that pattern meets `ext_i = 1` on a valid input. Across all `2^TBL_L` addresses, exactly one result differs from true round-half-up.
- R7: A cycle with `valid_i` low gives `valid_o = 0` and `sat_o = 0` on the next cycle, and leaves `sig_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input qualifier |
| sig_i | input | SIG_W | Significand before rounding |
| ext_i | input | 1 | Most significant discarded bit |
| valid_o | output | 1 | Result qualifier, one cycle after valid_i |
| sig_o | output | SIG_W | Rounded significand |
| sat_o | output | 1 | Truncation substitute taken for this result |

## Verification
A wrong table entry shows on the low field of `sig_o` one cycle after its address is presented. The bench sweeps every address with both values of the extra bit, so each entry is exposed within one pass of `2^TBL_L` cycles. Bad slicing of the pass-through field shows as a mismatch on the upper bits in the same cycle, because those bits carry varying random data. A faulty enable on the output register shows up right after an idle cycle, as a changed `sig_o` or a raised `valid_o` or `sat_o`.

// File: rtl/rnd_pkg.sv
package rnd_pkg;
  // Entry for one table address: {low_field, ext_bit}, round half up,
  // all-ones low field saturates instead of carrying out.
  function automatic int unsigned rom_entry(int unsigned addr, int unsigned data_w);
    int unsigned lo;
    int unsigned top;
    lo  = addr >> 1;
    top = (32'd1 << data_w) - 32'd1;
    if (lo == top) return top;
    return lo + (addr & 32'd1);
  endfunction
endpackage

// File: rtl/rnd_rom.sv
module rnd_rom #(
  parameter int TBL_L = 8
) (
  input  logic [TBL_L-1:0] addr_i,
  output logic [TBL_L-2:0] data_o
);
  localparam int DATA_W = TBL_L - 1;
  localparam int DEPTH  = 1 << TBL_L;

  logic [DATA_W-1:0] rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign rom[g] = DATA_W'(rnd_pkg::rom_entry(g, DATA_W));
  end

  assign data_o = rom[addr_i];
endmodule

// File: rtl/rnd_core.sv
module rnd_core #(
  parameter int SIG_W = 24,
  parameter int TBL_L = 8
) (
  input  logic [SIG_W-1:0] sig_i,
  input  logic             ext_i,
  output logic [SIG_W-1:0] sig_o,
  output logic             sat_o
);
  localparam int LOW_W = TBL_L - 1;

  logic [LOW_W-1:0] low_in;
  logic [LOW_W-1:0] low_rnd;

  assign low_in = sig_i[LOW_W-1:0];

  rnd_rom #(.TBL_L(TBL_L)) u_rom (
    .addr_i ({low_in, ext_i}),
    .data_o (low_rnd)
  );

  assign sat_o = (&low_in) & ext_i;

  if (SIG_W > LOW_W) begin : g_pass
    assign sig_o = {sig_i[SIG_W-1:LOW_W], low_rnd};
  end else begin : g_nopass
    assign sig_o = low_rnd;
  end
endmodule

// File: rtl/rom_rounder.sv
module rom_rounder #(
  parameter int SIG_W = 24,
  parameter int TBL_L = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [SIG_W-1:0] sig_i,
  input  logic             ext_i,
  output logic             valid_o,
  output logic [SIG_W-1:0] sig_o,
  output logic             sat_o
);
  localparam int LOW_W = TBL_L - 1;

  logic [SIG_W-1:0] core_sig;
  logic             core_sat;
  logic             valid_q;
  logic [SIG_W-1:0] sig_q;
  logic             sat_q;

  rnd_core #(.SIG_W(SIG_W), .TBL_L(TBL_L)) u_core (
    .sig_i (sig_i),
    .ext_i (ext_i),
    .sig_o (core_sig),
    .sat_o (core_sat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      sig_q   <= '0;
      sat_q   <= 1'b0;
    end else begin
      valid_q <= valid_i;
      sat_q   <= valid_i & core_sat;
      if (valid_i) sig_q <= core_sig;
    end
  end

  assign valid_o = valid_q;
  assign sig_o   = sig_q;
  assign sat_o   = sat_q;

  // R2
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  // R7
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && !sat_o && $stable(sig_o)));

  // R3
  upper_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (sig_o[SIG_W-1:LOW_W] == $past(sig_i[SIG_W-1:LOW_W])));

  // R4
  exact_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !ext_i) |=> (sig_o[LOW_W-1:0] == $past(sig_i[LOW_W-1:0])));

  // R5
  inc_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ext_i && !(&sig_i[LOW_W-1:0])) |=>
      (sig_o[LOW_W-1:0] == LOW_W'($past(sig_i[LOW_W-1:0]) + 1'b1)));

  // R6
  sat_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_o |-> (valid_o && (&sig_o[LOW_W-1:0])));
endmodule

// File: tb/rom_rounder_tb.sv
module rom_rounder_tb;
  localparam int SIG_W = 24;
  localparam int TBL_L = 8;
  localparam int LOW_W = TBL_L - 1;
  localparam int LMASK = (1 << LOW_W) - 1;

  logic             clk;
  logic             rst_n;
  logic             valid_in;
  logic [SIG_W-1:0] sig_in;
  logic             ext_in;
  logic             valid_out;
  logic [SIG_W-1:0] sig_out;
  logic             sat_out;

  int n_chk;
  int n_fail;
  int n_wrong_round;
  bit done;

  // reference state for the result due on the next cycle
  bit          e_valid;
  int unsigned e_sig;
  bit          e_sat;
  int unsigned e_hold;
  bit          e_idle;
  int          e_kind;   // 4: exact, 5: increment, 6: saturate

  rom_rounder #(.SIG_W(SIG_W), .TBL_L(TBL_L)) u_dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .valid_i (valid_in),
    .sig_i   (sig_in),
    .ext_i   (ext_in),
    .valid_o (valid_out),
    .sig_o   (sig_out),
    .sat_o   (sat_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int unsigned act, input int unsigned exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic compare();
    int unsigned so;
    so = int'(sig_out);
    chk(valid_out == e_valid, "R2 valid", valid_out, e_valid);
    chk(sat_out == e_sat, "R6 sat flag", sat_out, e_sat);
    if (e_idle) begin
      chk(so == e_hold, "R7 hold", so, e_hold);
    end else begin
      chk((so >> LOW_W) == (e_sig >> LOW_W), "R3 upper", so >> LOW_W, e_sig >> LOW_W);
      if (e_kind == 4)
        chk((so & LMASK) == (e_sig & LMASK), "R4 low exact", so & LMASK, e_sig & LMASK);
      else if (e_kind == 5)
        chk((so & LMASK) == (e_sig & LMASK), "R5 low inc", so & LMASK, e_sig & LMASK);
      else
        chk((so & LMASK) == (e_sig & LMASK), "R6 low sat", so & LMASK, e_sig & LMASK);
    end
  endtask

  // drive one cycle at the falling edge; check the previous result first
  task automatic step(input bit v, input int unsigned s, input bit x);
    int unsigned lo;
    int unsigned true_lo;
    @(negedge clk);
    compare();
    if (!e_idle && e_valid) begin
      e_hold = int'(sig_out);
    end
    valid_in = v;
    sig_in   = SIG_W'(s);
    ext_in   = x;
    lo       = s & LMASK;
    e_valid  = v;
    e_idle   = !v;
    e_sat    = v && x && (lo == LMASK);
    if (!x) begin
      e_kind = 4; e_sig = s;
    end else if (lo != LMASK) begin
      e_kind = 5; e_sig = (s & ~LMASK) | (lo + 1);
    end else begin
      e_kind = 6; e_sig = s;
    end
    true_lo = lo + (x ? 1 : 0);
    if (v && (e_sig & LMASK) != (true_lo & LMASK)) n_wrong_round++;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; n_wrong_round = 0; done = 0;
    rst_n = 1'b0; valid_in = 1'b0; sig_in = '0; ext_in = 1'b0;
    e_valid = 0; e_sig = 0; e_sat = 0; e_hold = 0; e_idle = 1; e_kind = 4;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(valid_out == 1'b0, "R1 valid", valid_out, 0);
    chk(sat_out == 1'b0, "R1 sat", sat_out, 0);
    chk(sig_out == '0, "R1 sig", int'(sig_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 first cycle after release
    chk(valid_out == 1'b0 && sat_out == 1'b0 && sig_out == '0, "R1 post", int'(sig_out), 0);

    // full table sweep, both extra-bit values, varying upper bits (R3-R6)
    for (int x = 0; x < 2; x++) begin
      for (int a = 0; a <= LMASK; a++) begin
        int unsigned up;
        up = $urandom & ((1 << (SIG_W - LOW_W)) - 1);
        step(1'b1, (up << LOW_W) | a, x[0]);
      end
    end
    @(negedge clk);
    compare();
    e_hold = int'(sig_out);
    e_valid = 0; e_sat = 0; e_idle = 1;
    valid_in = 1'b0;
    // R6: exactly one address of the sweep deviates from true rounding
    chk(n_wrong_round == 1, "R6 deviations", n_wrong_round, 1);

    // idle cycles with changing inputs (R7), including a saturating pattern
    step(1'b1, 32'h00ABCD7F, 1'b1);
    step(1'b0, 32'h00123456, 1'b1);
    step(1'b0, 32'h00FFFFFF, 1'b1);
    step(1'b1, 32'h00FFFFFF, 1'b1);
    step(1'b1, 32'h00FFFFFF, 1'b0);
    step(1'b1, 32'h0080007E, 1'b1);
    step(1'b0, 32'h00000000, 1'b0);
    // random mix
    for (int i = 0; i < 400; i++) begin
      step($urandom_range(0, 3) != 0, $urandom & 32'h00FFFFFF, $urandom_range(0, 1) != 0);
    end
    step(1'b0, 0, 1'b0);
    @(negedge clk);
    compare();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule